// File: doc/BRIEF.md
# Sequential Prefetch Stream Buffer

This block sits beside a cache and keeps a short ring of blocks fetched ahead of the most recent miss. The cache presents a block address to the probe port on every access, along with its own hit result. Only the oldest entry of the ring is compared. When the cache misses and that entry holds the probed block with its data present, the block goes out on the fill port to the cache in the same cycle. The entry is then retired, and its slot is reused for the next block in sequence, so the ring keeps running ahead.

When the cache misses and the oldest entry does not match, the ring is rebuilt. This happens even if some younger entry holds the block. The ring then covers the blocks that follow the missed one. Requests for the missed block itself are left to the cache's own refill path. A one-bit generation flag travels in every memory tag so that data coming back for an abandoned ring is thrown away. If the oldest entry matches but its data has not yet arrived, the block asks the requester to wait and sends no second request.

Memory requests leave one per accepted handshake, in ring order. Responses come back in request order. Each response carries the tag that was issued with its request.

Top module: `stream_prefetch_buf`

## Requirements
- R1: After reset the ring is empty: `fill_valid`, `prb_stall` and `mreq_valid` are all low until the first cache miss is probed.
- R2: A probe with `prb_valid` high and `prb_cache_hit` low whose block does not equal the oldest entry's block (or any miss while the ring is empty) rebuilds the ring. From the next cycle exactly DEPTH requests follow, for blocks X+1 to X+DEPTH (modulo 2^ADDR_W), X being the missed block.
- R3: While `mreq_valid` is high and `mreq_ready` is low, `mreq_blk` and `mreq_tag` hold their values, and no request is lost.
- R4: A cache-missing probe that matches the oldest entry while its data is present raises `fill_valid` in the same cycle, with that block on `fill_blk` and its data on `fill_data`. The entry is retired. A request for the block one past the youngest entry follows.
- R5: A cache-missing probe that matches the oldest entry while its data is absent raises `prb_stall`, gives no fill, issues no extra request and leaves the ring unchanged.
- R6: A cache-missing probe whose block is held by a younger entry but not by the oldest one is treated as a miss: no fill, no stall, and the ring is rebuilt from that block.
- R7: A probe with `prb_cache_hit` high gives no fill and no stall and leaves the ring unchanged.
- R8: A response whose generation bit differs from the current ring's is discarded. It never marks an entry as present.
- R9: `mreq_tag` is {generation, slot index}, with the generation in the top bit. The generation is 0 after reset and flips on every rebuild. Slot indices run 0,1,...,DEPTH-1 and then repeat in request order after a rebuild. A response whose tag carries the current generation marks the named slot present and stores `mrsp_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prb_valid | input | 1 | A cache access is being probed this cycle |
| prb_blk | input | ADDR_W | Block address of the access |
| prb_cache_hit | input | 1 | The cache itself hit this access |
| prb_stall | output | 1 | Oldest entry matches but its data is still in flight |
| fill_valid | output | 1 | Oldest entry is handed to the cache this cycle |
| fill_blk | output | ADDR_W | Block address of the oldest entry |
| fill_data | output | DATA_W | Data of the oldest entry |
| mreq_valid | output | 1 | A prefetch request is offered to memory |
| mreq_ready | input | 1 | Memory accepts the offered request |
| mreq_blk | output | ADDR_W | Block address requested |
| mreq_tag | output | log2(DEPTH)+1 | {generation, slot index} of the request |
| mrsp_valid | input | 1 | Memory returns data this cycle |
| mrsp_tag | input | log2(DEPTH)+1 | Tag of the returning request |
| mrsp_data | input | DATA_W | Returned block data |

## Verification
The bench builds the block with DEPTH=4, ADDR_W=8 and DATA_W=16. With these values, ten retirements per stream wrap the slot indices more than twice. One stream starts just below 8'hFF, so the block sequence also wraps through zero. The bench derives every expected request address, tag and fill datum arithmetically, as base+1+n, n mod 4 and {blk,~blk}, from a memory model that answers strictly in order. It orders stale responses from an abandoned ring so that they arrive after a rebuild.

// File: rtl/sb_pkg.sv
// Shared definitions for the stream buffer.
// Assumes nothing beyond IEEE 1800-2017.
package sb_pkg;
    // Outcome of one probe against the oldest ring entry.
    typedef enum logic [1:0] {
        PRB_IDLE  = 2'd0,   // no probe, or the cache hit
        PRB_FILL  = 2'd1,   // oldest entry matches and is present
        PRB_STALL = 2'd2,   // oldest entry matches, data in flight
        PRB_ALLOC = 2'd3    // cache missed elsewhere: rebuild ring
    } prb_act_e;
endpackage

// File: rtl/sb_seq.sv
// Control for the stream buffer: decides the probe outcome, keeps the ring
// head, the count of slots still to be requested, the generation bit and
// the next sequential block to assign.
// Assumes DEPTH is a power of two, at least 2.
module sb_seq
    import sb_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      prb_valid,
    input  logic [ADDR_W-1:0]         prb_blk,
    input  logic                      prb_cache_hit,
    input  logic [ADDR_W-1:0]         head_blk,
    input  logic                      head_rdy,
    input  logic                      mreq_ready,
    output prb_act_e                  act,
    output logic [$clog2(DEPTH)-1:0]  head_idx,
    output logic [$clog2(DEPTH)-1:0]  iss_idx,
    output logic                      mreq_valid,
    output logic                      gen,
    output logic [ADDR_W-1:0]         next_blk
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic             active;
    logic [CNT_W-1:0] iss_cnt;
    logic             head_match;
    logic             issue;

    // Classify the current probe.
    always_comb begin
        head_match = active && (prb_blk == head_blk);
        act        = PRB_IDLE;
        if (prb_valid && !prb_cache_hit) begin
            if (!head_match)   act = PRB_ALLOC;
            else if (head_rdy) act = PRB_FILL;
            else               act = PRB_STALL;
        end
    end

    // Unrequested slots are the youngest iss_cnt ones of the ring.
    assign iss_idx    = head_idx - iss_cnt[PTR_W-1:0];
    assign mreq_valid = active && (iss_cnt != '0);
    assign issue      = mreq_valid && mreq_ready;

    // Ring bookkeeping: rebuild on a miss, advance on a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            head_idx <= '0;
            iss_cnt  <= '0;
            gen      <= 1'b0;
            next_blk <= '0;
        end else if (act == PRB_ALLOC) begin
            active   <= 1'b1;
            head_idx <= '0;
            iss_cnt  <= CNT_W'(DEPTH);
            gen      <= ~gen;
            next_blk <= prb_blk + ADDR_W'(DEPTH + 1);
        end else begin
            if (act == PRB_FILL) begin
                head_idx <= head_idx + PTR_W'(1);
                next_blk <= next_blk + ADDR_W'(1);
            end
            iss_cnt <= iss_cnt + CNT_W'(act == PRB_FILL) - CNT_W'(issue);
        end
    end

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        iss_cnt <= CNT_W'(DEPTH));
    a_r4_refill_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (act == PRB_FILL) |=> (iss_cnt != '0));
    a_r5_stall_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
        (act == PRB_STALL) |=> ($stable(head_idx) && $stable(gen)));
    a_r9_gen_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (act == PRB_ALLOC) |=> (gen != $past(gen)));
endmodule

// File: rtl/sb_store.sv
// Entry storage for the stream buffer: per slot a block address, a
// present bit and the data. Rebuild rewrites every slot; a fill rewrites
// the retired slot with the next block; a response sets one slot present.
// Assumes a retired slot never has a response in flight.
module sb_store #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              alloc,
    input  logic [ADDR_W-1:0]                 alloc_blk,
    input  logic                              pop,
    input  logic [$clog2(DEPTH)-1:0]          pop_idx,
    input  logic [ADDR_W-1:0]                 refill_blk,
    input  logic                              rsp_we,
    input  logic [$clog2(DEPTH)-1:0]          rsp_idx,
    input  logic [DATA_W-1:0]                 rsp_data,
    output logic [DEPTH-1:0][ADDR_W-1:0]      blk_q,
    output logic [DEPTH-1:0]                  rdy_q,
    output logic [DEPTH-1:0][DATA_W-1:0]      dat_q
);
    localparam int PTR_W = $clog2(DEPTH);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Update one slot from rebuild, retirement or a response.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                blk_q[i] <= '0;
                rdy_q[i] <= 1'b0;
                dat_q[i] <= '0;
            end else if (alloc) begin
                blk_q[i] <= alloc_blk + ADDR_W'(i + 1);
                rdy_q[i] <= 1'b0;
            end else begin
                if (pop && pop_idx == PTR_W'(i)) begin
                    blk_q[i] <= refill_blk;
                    rdy_q[i] <= 1'b0;
                end
                if (rsp_we && rsp_idx == PTR_W'(i)) begin
                    rdy_q[i] <= 1'b1;
                    dat_q[i] <= rsp_data;
                end
            end
        end
    end

    a_r9_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && rsp_we && !alloc && pop_idx == rsp_idx));
    a_r4_pop_present: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !alloc) |=> !rdy_q[$past(pop_idx)]);
endmodule

// File: rtl/stream_prefetch_buf.sv
// Sequential prefetch stream buffer. Probed alongside the cache; serves
// the oldest prefetched block on a cache miss, rebuilds itself on any
// other cache miss, and keeps DEPTH sequential blocks requested ahead.
// Assumes memory answers in request order and DEPTH is a power of two.
module stream_prefetch_buf
    import sb_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int TAG_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prb_valid,
    input  logic [ADDR_W-1:0] prb_blk,
    input  logic              prb_cache_hit,
    output logic              prb_stall,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_blk,
    output logic [DATA_W-1:0] fill_data,
    output logic              mreq_valid,
    input  logic              mreq_ready,
    output logic [ADDR_W-1:0] mreq_blk,
    output logic [TAG_W-1:0]  mreq_tag,
    input  logic              mrsp_valid,
    input  logic [TAG_W-1:0]  mrsp_tag,
    input  logic [DATA_W-1:0] mrsp_data
);
    prb_act_e                    act;
    logic [PTR_W-1:0]            head_idx;
    logic [PTR_W-1:0]            iss_idx;
    logic                        gen;
    logic [ADDR_W-1:0]           next_blk;
    logic [DEPTH-1:0][ADDR_W-1:0] blk_q;
    logic [DEPTH-1:0]            rdy_q;
    logic [DEPTH-1:0][DATA_W-1:0] dat_q;
    logic                        rsp_we;

    sb_seq #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .prb_valid     (prb_valid),
        .prb_blk       (prb_blk),
        .prb_cache_hit (prb_cache_hit),
        .head_blk      (blk_q[head_idx]),
        .head_rdy      (rdy_q[head_idx]),
        .mreq_ready    (mreq_ready),
        .act           (act),
        .head_idx      (head_idx),
        .iss_idx       (iss_idx),
        .mreq_valid    (mreq_valid),
        .gen           (gen),
        .next_blk      (next_blk)
    );

    // Accept only responses that belong to the current ring.
    assign rsp_we = mrsp_valid && (mrsp_tag[TAG_W-1] == gen);

    sb_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc      (act == PRB_ALLOC),
        .alloc_blk  (prb_blk),
        .pop        (act == PRB_FILL),
        .pop_idx    (head_idx),
        .refill_blk (next_blk),
        .rsp_we     (rsp_we),
        .rsp_idx    (mrsp_tag[PTR_W-1:0]),
        .rsp_data   (mrsp_data),
        .blk_q      (blk_q),
        .rdy_q      (rdy_q),
        .dat_q      (dat_q)
    );

    // Drive the probe, fill and request ports from the ring.
    assign prb_stall  = (act == PRB_STALL);
    assign fill_valid = (act == PRB_FILL);
    assign fill_blk   = blk_q[head_idx];
    assign fill_data  = dat_q[head_idx];
    assign mreq_blk   = blk_q[iss_idx];
    assign mreq_tag   = {gen, iss_idx};

    a_r4_fill_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_valid && prb_stall));
    a_r2_first_req: assert property (@(posedge clk) disable iff (!rst_n)
        (act == PRB_ALLOC) |=> (mreq_valid && mreq_blk == $past(prb_blk) + ADDR_W'(1)
                                && mreq_tag[PTR_W-1:0] == '0));
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mreq_valid && !mreq_ready && act != PRB_ALLOC)
        |=> (mreq_valid && $stable(mreq_blk) && $stable(mreq_tag)));
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        prb_stall |=> $stable(fill_blk));
    a_r7_cache_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (prb_valid && prb_cache_hit) |=> $stable(fill_blk));
    a_r8_stale_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mrsp_valid && mrsp_tag[TAG_W-1] != gen && act != PRB_ALLOC && act != PRB_FILL)
        |=> $stable(rdy_q));
endmodule

// File: tb/test_stream_prefetch_buf.sv
module test_stream_prefetch_buf;
    localparam int DEPTH = 4, AW = 8, DW = 16, TW = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic pv = 0, chit = 0, rdy = 0, rv = 0;
    logic [AW-1:0] pa = '0;
    logic [TW-1:0] rt = '0;
    logic [DW-1:0] rd = '0;
    logic prb_stall, fill_valid, mreq_valid;
    logic [AW-1:0] fill_blk, mreq_blk;
    logic [DW-1:0] fill_data;
    logic [TW-1:0] mreq_tag;

    always #4 clk = ~clk;

    stream_prefetch_buf #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW)) i_stream_prefetch_buf (
        .clk(clk), .rst_n(rst_n), .prb_valid(pv), .prb_blk(pa), .prb_cache_hit(chit),
        .prb_stall(prb_stall), .fill_valid(fill_valid), .fill_blk(fill_blk),
        .fill_data(fill_data), .mreq_valid(mreq_valid), .mreq_ready(rdy),
        .mreq_blk(mreq_blk), .mreq_tag(mreq_tag), .mrsp_valid(rv), .mrsp_tag(rt),
        .mrsp_data(rd));

    int n_tests = 0, n_fail = 0;
    logic [AW-1:0] q_blk [0:255];
    logic [TW-1:0] q_tag [0:255];
    int q_wr = 0, q_rd = 0;
    int exp_base = 0, exp_n = 0;
    logic exp_gen = 1'b0;
    logic s_fill, s_stall, s_mv;
    logic [AW-1:0] s_fblk, s_mblk;
    logic [DW-1:0] s_fdat;
    logic [TW-1:0] s_mtag;

    function automatic logic [DW-1:0] fdat(input logic [AW-1:0] b);
        return {b, ~b};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // One cycle: drive inputs, sample outputs, record accepted requests.
    task automatic cyc(input logic v, input logic [AW-1:0] a, input logic h,
                       input logic r, input logic re);
        logic [AW-1:0] eb;
        logic [TW-1:0] et;
        pv = v; pa = a; chit = h; rdy = r;
        if (re && q_rd != q_wr) begin
            rv = 1'b1; rt = q_tag[q_rd[7:0]]; rd = fdat(q_blk[q_rd[7:0]]); q_rd++;
        end else rv = 1'b0;
        #1;
        s_fill = fill_valid; s_stall = prb_stall; s_mv = mreq_valid;
        s_fblk = fill_blk; s_fdat = fill_data; s_mblk = mreq_blk; s_mtag = mreq_tag;
        if (mreq_valid && rdy) begin
            eb = AW'(exp_base + 1 + exp_n);
            et = {exp_gen, 2'(exp_n % DEPTH)};
            chk(mreq_blk == eb, "R2 request block", int'(mreq_blk), int'(eb));
            chk(mreq_tag == et, "R9 request tag", int'(mreq_tag), int'(et));
            q_blk[q_wr[7:0]] = mreq_blk; q_tag[q_wr[7:0]] = mreq_tag; q_wr++;
            exp_n++;
        end
        @(posedge clk); #2;
    endtask

    task automatic new_stream(input logic [AW-1:0] b);
        exp_base = int'(b); exp_n = 0; exp_gen = ~exp_gen;
    endtask

    task automatic drain();
        for (int i = 0; i < 300 && q_rd != q_wr; i++) cyc(0, '0, 0, 0, 1);
    endtask

    // Consume block b, waiting through stalls.
    task automatic consume(input logic [AW-1:0] b, input string req);
        bit done = 0;
        for (int i = 0; i < 12 && !done; i++) begin
            cyc(1, b, 0, 1, 1);
            if (s_fill) begin
                chk(s_fblk == b, req, int'(s_fblk), int'(b));
                chk(s_fdat == fdat(b), req, int'(s_fdat), int'(fdat(b)));
                done = 1;
            end else if (!s_stall) begin
                chk(0, {req, " unexpected miss"}, 0, int'(b));
                done = 1;
            end
        end
        if (!done) chk(0, {req, " never filled"}, 0, int'(b));
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1: quiet after reset
        pv = 0; #1;
        chk(!fill_valid && !prb_stall && !mreq_valid, "R1 reset outputs",
            int'({fill_valid, prb_stall, mreq_valid}), 0);
        @(posedge clk); #2;
        cyc(1, 8'h10, 1, 1, 0);
        chk(!s_mv && !s_fill, "R1 cache hit on empty ring", int'({s_mv, s_fill}), 0);

        // R2/R3/R9: rebuild on first miss, requests held while not ready
        cyc(1, 8'h10, 0, 0, 0);
        new_stream(8'h10);
        cyc(0, '0, 0, 0, 0);
        chk(s_mv && s_mblk == 8'h11, "R2 first request", int'(s_mblk), 8'h11);
        chk(s_mtag == 3'b100, "R9 first tag", int'(s_mtag), 3'b100);
        cyc(0, '0, 0, 0, 0);
        chk(s_mv && s_mblk == 8'h11 && s_mtag == 3'b100, "R3 held request",
            int'(s_mblk), 8'h11);
        for (int i = 0; i < DEPTH; i++) cyc(0, '0, 0, 1, 0);
        cyc(0, '0, 0, 1, 0);
        chk(!s_mv, "R2 exactly DEPTH requests", int'(s_mv), 0);

        // R5: match on oldest entry before data arrives
        cyc(1, 8'h11, 0, 1, 0);
        chk(s_stall && !s_fill && !s_mv, "R5 stall", int'({s_stall, s_fill, s_mv}), 3'b100);
        cyc(1, 8'h11, 0, 1, 0);
        chk(s_stall && !s_mv, "R5 ring unchanged", int'({s_stall, s_mv}), 2'b10);
        for (int i = 0; i < DEPTH; i++) cyc(0, '0, 0, 1, 1);

        // R4: fill from oldest entry then replenish
        cyc(1, 8'h11, 0, 1, 1);
        chk(s_fill && s_fblk == 8'h11, "R4 fill block", int'(s_fblk), 8'h11);
        chk(s_fdat == fdat(8'h11), "R4 fill data", int'(s_fdat), int'(fdat(8'h11)));
        cyc(0, '0, 0, 1, 1);
        chk(s_mv && s_mblk == 8'h15, "R4 replenish request", int'(s_mblk), 8'h15);

        // R7: cache hit leaves ring untouched
        cyc(1, 8'h12, 1, 1, 1);
        chk(!s_fill && !s_stall, "R7 no action on cache hit", int'({s_fill, s_stall}), 0);
        cyc(1, 8'h12, 0, 1, 1);
        chk(s_fill && s_fblk == 8'h12, "R7 head still present", int'(s_fblk), 8'h12);

        // R6: younger-entry match rebuilds
        cyc(1, 8'h14, 0, 0, 1);
        chk(!s_fill && !s_stall, "R6 treated as miss", int'({s_fill, s_stall}), 0);
        new_stream(8'h14);
        cyc(0, '0, 0, 0, 1);
        chk(s_mv && s_mblk == 8'h15 && s_mtag == 3'b000, "R6 rebuilt ring",
            int'({s_mtag, s_mblk}), int'({3'b000, 8'h15}));

        // R8: responses of an abandoned ring are ignored
        drain();
        for (int i = 0; i < DEPTH; i++) cyc(0, '0, 0, 1, 0);
        cyc(1, 8'h40, 0, 0, 0);
        new_stream(8'h40);
        for (int i = 0; i < DEPTH; i++) cyc(0, '0, 0, 0, 1);
        cyc(1, 8'h41, 0, 0, 0);
        chk(s_stall && !s_fill, "R8 stale data discarded", int'({s_stall, s_fill}), 2'b10);
        consume(8'h41, "R8 later fill");

        // Sweep: several streams, index and address wrap (R2 R4 R9)
        foreach (q_blk[i]) if (i < 3) begin
            logic [AW-1:0] b;
            b = (i == 0) ? 8'h80 : (i == 1) ? 8'hFC : 8'h23;
            drain();
            cyc(1, b, 0, 0, 0);
            new_stream(b);
            for (int k = 1; k <= 10; k++) consume(AW'(int'(b) + k), "R4 sweep fill");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule